// File: doc/BRIEF.md
# Task Priority Interrupt Gate

This block filters a set of external interrupt request lines through a single programmable priority threshold. Every line carries a 4-bit priority class, where 1 is the least urgent and 15 the most urgent. Software sets a threshold through a write port that is wider than the threshold itself. The block then offers the most urgent request whose class lies strictly above that threshold to a downstream consumer over a valid/acknowledge handshake.

A request that arrives on a line with a non-zero class is latched as pending, together with its class. Pending requests at or below the threshold are not discarded. They wait until the threshold drops below their class. Lowering the threshold to 0 opens the gate to every class, and raising it to 15 closes it completely. A write that sets any bit above the low nibble is refused. The refused write leaves the threshold untouched and raises an error flag.

Top module: `tpr_irq_gate`

## Requirements
- R1: After reset the threshold is 0, and the read port returns the threshold zero-extended to the full register width; no request is offered and the error flag is low.
- R2: A write whose bits above bit 3 are all zero loads bits 3:0 as the new threshold; the new value is visible on the read port in the cycle after the write.
- R3: A write with any bit above bit 3 set leaves the threshold unchanged and sets the write-error flag; the flag stays set until the next accepted write clears it.
- R4: A request is offered only while its class is strictly greater than the threshold in effect.
- R5: With threshold 0 a request of every class from 1 to 15 is offered.
- R6: With threshold 15 nothing is offered.
- R7: A request raised on a line whose class input is 0 is ignored and never becomes pending.
- R8: Among offered candidates the highest class wins, and within one class the lowest line index wins.
- R9: The offered valid, index and class hold steady until acknowledged. An acknowledge removes that line's pending request on the same clock edge. The next winner may then be offered in the following cycle.
- R10: A request blocked by the threshold stays pending and is offered once the threshold is lowered below its class.
- R11: If a threshold write blocks the request being offered, the offer is withdrawn on the edge where the new threshold takes effect. The request stays pending.
- R12: A new request on a line that is already pending is ignored, and the stored class is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Threshold register write strobe |
| cfg_wr_data | input | REG_W | Write data; only bits 3:0 may be non-zero |
| cfg_rd_data | output | REG_W | Threshold, zero-extended |
| cfg_wr_err | output | 1 | Set by a refused write, cleared by an accepted one |
| irq_req | input | NUM_REQ | One request strobe per line |
| irq_cls | input | NUM_REQ*4 | Class of each line, line i in bits 4i+3:4i |
| out_valid | output | 1 | A request is offered |
| out_idx | output | clog2(NUM_REQ) | Line index of the offered request |
| out_cls | output | 4 | Class of the offered request |
| out_ack | input | 1 | Consumer takes the offered request |

## Verification
The hardest state to reach from the ports is an offer that is pulled back while it waits for its acknowledge. It takes an offer held without acknowledge while a threshold write lands on the same edge, at a class that the write blocks. The random phase holds acknowledges back about half the time and mixes threshold writes into the request traffic, so offers meet new thresholds in many orders. Directed sequences build the withdraw-then-restore case on purpose. They also build the cases of a re-request to a line that is already pending and of several equal classes raised in one cycle.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
    // Priority class width is fixed by the function: classes 0..15.
    localparam int unsigned CLS_W = 4;
    typedef logic [CLS_W-1:0] cls_t;
    localparam cls_t CLS_MAX = '1;
endpackage

// File: rtl/tpr_thresh_reg.sv
module tpr_thresh_reg
    import tpr_pkg::*;
#(
    parameter int unsigned REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cls_t             thr_q,
    output cls_t             thr_nxt,
    output logic             err_q,
    output logic [REG_W-1:0] rd_data
);
    localparam int unsigned RSVD_W = REG_W - CLS_W;

    typedef struct packed {
        cls_t thr;
        logic err;
    } thr_st_t;

    thr_st_t st_d, st_q;
    logic    rsvd_hit;

    always_comb begin
        st_d     = st_q;
        rsvd_hit = |wr_data[REG_W-1:CLS_W];
        if (wr_en) begin
            if (rsvd_hit) begin
                st_d.err = 1'b1;
            end else begin
                st_d.thr = wr_data[CLS_W-1:0];
                st_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_q   = st_q.thr;
    assign thr_nxt = st_d.thr;
    assign err_q   = st_q.err;
    assign rd_data = {{RSVD_W{1'b0}}, st_q.thr};

    // R3: refused write keeps the old threshold and flags the error
    p_bad_write_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && rsvd_hit |=> $stable(rd_data) && err_q);

    // R2: accepted write appears on the read port next cycle
    p_good_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rsvd_hit |=> rd_data == $past(wr_data) && !err_q);
endmodule

// File: rtl/tpr_pend_store.sv
module tpr_pend_store
    import tpr_pkg::*;
#(
    parameter int unsigned NUM_REQ = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req,
    input  logic [NUM_REQ*CLS_W-1:0] cls_in,
    input  logic [NUM_REQ-1:0]       clr,
    output logic [NUM_REQ-1:0]       pend_q,
    output logic [NUM_REQ*CLS_W-1:0] cls_q
);
    typedef struct packed {
        logic [NUM_REQ-1:0]       pend;
        logic [NUM_REQ*CLS_W-1:0] cls;
    } pend_st_t;

    pend_st_t           st_d, st_q;
    logic [NUM_REQ-1:0] req_ok;
    logic [NUM_REQ-1:0] kept;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REQ; i++) begin
            req_ok[i] = req[i] && (cls_in[i*CLS_W +: CLS_W] != '0);
            kept[i]   = st_q.pend[i] && !clr[i];
            st_d.pend[i] = kept[i] || req_ok[i];
            // a line that is still pending keeps its class
            if (req_ok[i] && !kept[i]) begin
                st_d.cls[i*CLS_W +: CLS_W] = cls_in[i*CLS_W +: CLS_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign cls_q  = st_q.cls;

    // R9: an acknowledge clears the pending bit on the same edge
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr & ~req_ok) |=> (pend_q & $past(clr & ~req_ok)) == '0);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_line_chk
        // R7: a pending line never holds class 0
        p_no_cls0_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[g] |-> cls_q[g*CLS_W +: CLS_W] != '0);
        // R12: a pending line keeps its class while not cleared
        p_class_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[g] && !clr[g] |=> $stable(cls_q[g*CLS_W +: CLS_W]));
    end
endmodule

// File: rtl/tpr_arbiter.sv
module tpr_arbiter
    import tpr_pkg::*;
#(
    parameter int unsigned NUM_REQ = 8,
    localparam int unsigned IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       pend,
    input  logic [NUM_REQ*CLS_W-1:0] cls,
    input  cls_t                     thr,
    output logic                     hit,
    output logic [IDX_W-1:0]         win_idx,
    output cls_t                     win_cls
);
    logic [NUM_REQ-1:0] elig;

    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_cls = '0;
        // scan from the top down, >= lets the lower index take a tie
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            elig[i] = pend[i] && (cls[i*CLS_W +: CLS_W] > thr);
            if (elig[i] && (!hit || cls[i*CLS_W +: CLS_W] >= win_cls)) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
                win_cls = cls[i*CLS_W +: CLS_W];
            end
        end
    end

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_arb_chk
        // R8: no eligible line outranks the winner
        p_none_higher_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] && cls[g*CLS_W +: CLS_W] > thr |->
                hit && win_cls >= cls[g*CLS_W +: CLS_W]);
        // R8: equal class ties go to the lowest index
        p_tie_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hit && pend[g] && cls[g*CLS_W +: CLS_W] > thr &&
            cls[g*CLS_W +: CLS_W] == win_cls |-> win_idx <= IDX_W'(g));
    end
endmodule

// File: rtl/tpr_irq_gate.sv
module tpr_irq_gate
    import tpr_pkg::*;
#(
    parameter int unsigned NUM_REQ = 8,
    parameter int unsigned REG_W   = 64,
    localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_en,
    input  logic [REG_W-1:0]         cfg_wr_data,
    output logic [REG_W-1:0]         cfg_rd_data,
    output logic                     cfg_wr_err,
    input  logic [NUM_REQ-1:0]       irq_req,
    input  logic [NUM_REQ*CLS_W-1:0] irq_cls,
    output logic                     out_valid,
    output logic [IDX_W-1:0]         out_idx,
    output logic [CLS_W-1:0]         out_cls,
    input  logic                     out_ack
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        cls_t             cls;
    } offer_t;

    offer_t                     st_d, st_q;
    cls_t                       thr_q, thr_nxt;
    logic [NUM_REQ-1:0]         pend_q, clr, cand;
    logic [NUM_REQ*CLS_W-1:0]   pcls_q;
    logic                       hit;
    logic [IDX_W-1:0]           win_idx;
    cls_t                       win_cls;

    tpr_thresh_reg #(.REG_W(REG_W)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .thr_q   (thr_q),
        .thr_nxt (thr_nxt),
        .err_q   (cfg_wr_err),
        .rd_data (cfg_rd_data)
    );

    tpr_pend_store #(.NUM_REQ(NUM_REQ)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (irq_req),
        .cls_in (irq_cls),
        .clr    (clr),
        .pend_q (pend_q),
        .cls_q  (pcls_q)
    );

    tpr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (cand),
        .cls     (pcls_q),
        .thr     (thr_nxt),
        .hit     (hit),
        .win_idx (win_idx),
        .win_cls (win_cls)
    );

    always_comb begin
        clr = '0;
        if (st_q.valid && out_ack) begin
            clr[st_q.idx] = 1'b1;
        end
        cand = pend_q & ~clr;

        st_d = st_q;
        if (st_q.valid && !out_ack) begin
            // hold the offer unless the incoming threshold blocks it
            if (st_q.cls <= thr_nxt) begin
                st_d = '0;
            end
        end else begin
            st_d.valid = hit;
            st_d.idx   = win_idx;
            st_d.cls   = win_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_idx   = st_q.idx;
    assign out_cls   = st_q.cls;

    // R4: an offered class is always above the threshold in effect
    p_above_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cls > thr_q);

    // R6: a closed gate offers nothing
    p_closed_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        thr_q == CLS_MAX |-> !out_valid);

    // R9: an unacknowledged, still-unblocked offer holds steady
    p_offer_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack && out_cls > thr_nxt |=>
            out_valid && $stable(out_idx) && $stable(out_cls));

    // R11: a threshold that blocks the offer withdraws it, the line stays pending
    p_withdraw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack && out_cls <= thr_nxt |=>
            !out_valid && pend_q[$past(out_idx)]);
endmodule

// File: tb/tpr_irq_gate_bench.sv
module tpr_irq_gate_bench;
    localparam int NR = 8;
    localparam int RW = 64;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr_en = 1'b0;
    logic [RW-1:0]   cfg_wr_data = '0;
    logic [RW-1:0]   cfg_rd_data;
    logic            cfg_wr_err;
    logic [NR-1:0]   irq_req = '0;
    logic [NR*4-1:0] irq_cls = '0;
    logic            out_valid;
    logic [IW-1:0]   out_idx;
    logic [3:0]      out_cls;
    logic            out_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    tpr_irq_gate u_tpr_irq_gate (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .cfg_wr_err(cfg_wr_err),
        .irq_req(irq_req), .irq_cls(irq_cls),
        .out_valid(out_valid), .out_idx(out_idx), .out_cls(out_cls),
        .out_ack(out_ack)
    );

    // ---------------- reference model from the requirements ----------------
    logic       m_pend [NR];
    logic [3:0] m_cls  [NR];
    logic [3:0] m_thr;
    logic       m_err, m_ov;
    logic [IW-1:0] m_oi;
    logic [3:0] m_oc;

    logic       n_p2 [NR];
    logic [3:0] n_thr;
    logic       n_err, n_ov, n_hit;
    logic [IW-1:0] n_oi;
    logic [3:0] n_oc;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin m_pend[i] = 0; m_cls[i] = 0; end
            m_thr = 0; m_err = 0; m_ov = 0; m_oi = 0; m_oc = 0;
        end else begin
            n_thr = m_thr; n_err = m_err;
            if (cfg_wr_en) begin
                if (cfg_wr_data[RW-1:4] != 0) n_err = 1;          // R3
                else begin n_thr = cfg_wr_data[3:0]; n_err = 0; end // R2
            end
            for (int i = 0; i < NR; i++)
                n_p2[i] = m_pend[i] && !(m_ov && out_ack && m_oi == IW'(i));
            n_ov = m_ov; n_oi = m_oi; n_oc = m_oc;
            if (m_ov && !out_ack) begin
                if (m_oc <= n_thr) begin n_ov = 0; n_oi = 0; n_oc = 0; end // R11
            end else begin
                n_hit = 0; n_oi = 0; n_oc = 0;
                for (int i = 0; i < NR; i++)                       // R8
                    if (n_p2[i] && m_cls[i] > n_thr && (!n_hit || m_cls[i] > n_oc)) begin
                        n_hit = 1; n_oi = IW'(i); n_oc = m_cls[i];
                    end
                n_ov = n_hit;
            end
            for (int i = 0; i < NR; i++) begin
                if (irq_req[i] && irq_cls[i*4 +: 4] != 0 && !n_p2[i]) // R7 R12
                    m_cls[i] = irq_cls[i*4 +: 4];
                m_pend[i] = n_p2[i] || (irq_req[i] && irq_cls[i*4 +: 4] != 0);
            end
            m_thr = n_thr; m_err = n_err; m_ov = n_ov; m_oi = n_oi; m_oc = n_oc;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R9 model out_valid", 64'(out_valid), 64'(m_ov));
            if (m_ov) begin
                check("R8 model out_idx", 64'(out_idx), 64'(m_oi));
                check("R4 model out_cls", 64'(out_cls), 64'(m_oc));
            end
            check("R2 model rd_data", cfg_rd_data, 64'(m_thr));
            check("R3 model wr_err", 64'(cfg_wr_err), 64'(m_err));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [RW-1:0] d);
        cfg_wr_en = 1; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0; cfg_wr_data = '0;
    endtask

    task automatic raise(input int line, input logic [3:0] c);
        irq_req[line] = 1; irq_cls[line*4 +: 4] = c;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic ack1();
        out_ack = 1;
        @(negedge clk);
        out_ack = 0;
    endtask

    task automatic drain();
        wr(0);
        for (int k = 0; k < 40; k++) begin
            out_ack = out_valid;
            @(negedge clk);
        end
        out_ack = 0;
    endtask

    initial begin
        void'($urandom(32'd4021));
        tick(4);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        check("R1 reset rd_data", cfg_rd_data, 0);
        check("R1 reset out_valid", 64'(out_valid), 0);
        check("R1 reset wr_err", 64'(cfg_wr_err), 0);

        wr(64'h5);
        check("R2 accepted write", cfg_rd_data, 64'h5);
        wr((64'h1 << 40) | 64'h9);
        check("R3 refused write keeps", cfg_rd_data, 64'h5);
        check("R3 refused write flag", 64'(cfg_wr_err), 1);
        wr(64'h8000_0000_0000_0000);
        check("R3 flag still set", 64'(cfg_wr_err), 1);
        wr(64'h3);
        check("R3 flag cleared", 64'(cfg_wr_err), 0);

        // R6 closed gate, then R10/R5 release
        wr(64'hF);
        irq_req = '1;
        for (int i = 0; i < NR; i++) irq_cls[i*4 +: 4] = 4'(i + 8);
        @(negedge clk);
        irq_req = '0;
        tick(3);
        check("R6 nothing offered at 15", 64'(out_valid), 0);
        wr(64'h0);
        check("R10 held request released", 64'(out_valid), 1);
        check("R8 top class first", 64'(out_cls), 15);
        for (int k = 0; k < 7; k++) begin
            ack1();
            check("R9 next after ack", 64'(out_cls), 64'(14 - k));
        end
        ack1();
        check("R9 queue empty", 64'(out_valid), 0);

        raise(0, 4'd1);
        tick(1);
        check("R5 class 1 passes at 0", 64'(out_valid), 1);
        check("R5 class 1 value", 64'(out_cls), 1);
        ack1();

        // R8 ties
        irq_req = 8'b0110_0110;
        irq_cls = '0;
        irq_cls[2*4 +: 4] = 7; irq_cls[5*4 +: 4] = 7;
        irq_cls[6*4 +: 4] = 7; irq_cls[1*4 +: 4] = 4;
        @(negedge clk);
        irq_req = '0;
        tick(1);
        check("R8 tie lowest index", 64'(out_idx), 2);
        tick(3);
        check("R9 held without ack", 64'(out_idx), 2);
        ack1();
        check("R8 tie second", 64'(out_idx), 5);
        ack1();
        check("R8 tie third", 64'(out_idx), 6);
        ack1();
        check("R8 lower class last", 64'(out_idx), 1);
        ack1();

        raise(0, 4'd0);
        tick(3);
        check("R7 class 0 ignored", 64'(out_valid), 0);

        // R4 boundary: class equal to threshold is blocked
        wr(64'h6);
        raise(3, 4'd6);
        raise(4, 4'd7);
        tick(1);
        check("R4 above threshold offered", 64'(out_idx), 4);
        ack1();
        check("R4 equal class blocked", 64'(out_valid), 0);
        drain();

        // R11 withdraw and restore
        wr(64'h2);
        raise(3, 4'd5);
        tick(1);
        check("R11 offer before raise", 64'(out_valid), 1);
        wr(64'h9);
        check("R11 offer withdrawn", 64'(out_valid), 0);
        wr(64'h0);
        check("R11 request kept pending", 64'(out_idx), 3);
        ack1();

        // R12 re-request to pending line
        wr(64'h8);
        raise(4, 4'd3);
        raise(4, 4'd12);
        tick(2);
        check("R12 still blocked", 64'(out_valid), 0);
        wr(64'h0);
        check("R12 class kept", 64'(out_cls), 3);
        drain();

        // random phase
        for (int k = 0; k < 5000; k++) begin
            for (int i = 0; i < NR; i++) begin
                irq_req[i] = ($urandom % 8) == 0;
                irq_cls[i*4 +: 4] = 4'($urandom % 16);
            end
            out_ack = out_valid && ($urandom % 2 == 0);
            if ($urandom % 16 == 0) begin
                cfg_wr_en = 1;
                if ($urandom % 5 == 0)
                    cfg_wr_data = (64'h1 << (4 + $urandom % 60)) | 64'($urandom % 16);
                else
                    cfg_wr_data = 64'($urandom % 16);
            end else begin
                cfg_wr_en = 0;
                cfg_wr_data = '0;
            end
            @(negedge clk);
        end
        irq_req = '0; cfg_wr_en = 0; out_ack = 0;
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule